// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, on every clock, which of the resident warps of one streaming multiprocessor sends its next instruction down the pipe. A warp is a group of 32 threads that share one program counter. Moving from one warp to another costs nothing, so the scheduler can hand the slot to a different warp on each cycle. It hides memory latency by running warps that still have work while other warps wait on returns.

A warp enters through the launch port, which places it in the lowest free slot. It leaves when it issues an exit instruction. For every warp, a small counter records the long-latency loads it has sent that have not yet returned. An instruction that consumes load data is held back while that counter is nonzero. A separate instruction buffer, outside this block, presents the class of each warp's next instruction: its presence, whether it is a load, whether it depends on a load, and whether it is an exit. The scheduler returns the chosen warp and its program counter.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no slot is occupied, `issue_valid` is low and `launch_ready` is high.
- R2: A launch with `launch_ready` high takes the lowest-numbered free slot, reported on `launch_slot`. Its `occupancy` bit is set on the next cycle and its program counter starts at `launch_pc`.
- R3: While all slots are occupied, `launch_ready` is low and a launch request leaves `occupancy` unchanged.
- R4: A warp is eligible when four conditions hold: it is occupied, its buffer-valid bit is set, it is not blocked, and its counter is not saturated for a load. A warp is blocked when its next instruction depends on a load or is an exit while its pending-load count is nonzero. A load is held back while the count sits at its maximum value of 7.
- R5: Among eligible warps, the first one found scanning upward from the warp after the last issuer (wrapping at the slot count) is issued. After reset the scan starts at slot 0.
- R6: Each warp issues in program order: each issue by a warp shows a program counter one greater than its previous issue.
- R7: Issuing a load raises that warp's pending count by one. A return token naming the warp lowers it by one. Both in the same cycle leave it unchanged. A token for a warp whose count is zero is ignored.
- R8: When no warp is eligible, `issue_valid` is low in that cycle.
- R9: Issuing an exit raises `retire_valid` in the same cycle with the slot on `retire_slot`. The slot's `occupancy` bit clears on the next cycle and the slot can be launched again.
- R10: `issue_warp` always names an occupied slot when `issue_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Request to start a new warp |
| launch_pc | input | 16 | Start program counter of the new warp |
| launch_ready | output | 1 | A free slot exists |
| launch_slot | output | 5 | Slot the launch would take |
| occupancy | output | 24 | One bit per occupied slot |
| nxt_valid | input | 24 | Per warp: next instruction present |
| nxt_load | input | 24 | Per warp: next instruction is a long-latency load |
| nxt_dep | input | 24 | Per warp: next instruction reads pending load data |
| nxt_exit | input | 24 | Per warp: next instruction is an exit |
| ret_valid | input | 1 | Load return token |
| ret_warp | input | 5 | Warp the token belongs to |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | 5 | Issuing warp |
| issue_pc | output | 16 | Program counter of the issued instruction |
| issue_load | output | 1 | Issued instruction is a load |
| issue_exit | output | 1 | Issued instruction is an exit |
| retire_valid | output | 1 | A slot is being freed |
| retire_slot | output | 5 | Slot being freed |

## Verification
A load issue and a return token can reach the same warp in the same cycle. Launch and retire can also fall in the same cycle. The bench sends return tokens mostly to warps that have loads outstanding, so the same-warp case keeps recurring. It also keeps launch requests running while warps exit. A behavioural model tracks every warp's count, program counter and slot state. Each cycle it predicts the chosen warp, and a wrong net count soon shows up as a dependent instruction that issues early or stalls too long. A launch that grabs a slot in its retire cycle shows up as a `launch_slot` or `occupancy` mismatch.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 24,
  parameter int PC_W = 16,
  parameter int CNT_W = 3,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [PC_W-1:0]      launch_pc,
  output logic                 launch_ready,
  output logic [WID_W-1:0]     launch_slot,
  output logic [NUM_WARPS-1:0] occupancy,
  input  logic [NUM_WARPS-1:0] nxt_valid,
  input  logic [NUM_WARPS-1:0] nxt_load,
  input  logic [NUM_WARPS-1:0] nxt_dep,
  input  logic [NUM_WARPS-1:0] nxt_exit,
  input  logic                 ret_valid,
  input  logic [WID_W-1:0]     ret_warp,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [PC_W-1:0]      issue_pc,
  output logic                 issue_load,
  output logic                 issue_exit,
  output logic                 retire_valid,
  output logic [WID_W-1:0]     retire_slot
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_WARPS-1:0] occ, elig, inc_v, dec_v;
  logic [PC_W-1:0]      pc  [NUM_WARPS];
  logic [CNT_W-1:0]     cnt [NUM_WARPS];
  logic [WID_W-1:0]     last, sel, free_slot;
  logic                 found, launch_fire;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    logic busy;
    assign busy     = cnt[g] != '0;
    assign elig[g]  = occ[g] & nxt_valid[g]
                    & ~(busy & (nxt_dep[g] | nxt_exit[g]))
                    & ~(nxt_load[g] & (cnt[g] == CNT_MAX));
    assign inc_v[g] = issue_load && (sel == WID_W'(g));
    assign dec_v[g] = ret_valid && (ret_warp == WID_W'(g)) && busy;
  end

  always_comb begin
    int idx;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      idx = int'(last) + 1 + k;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!found && elig[idx]) begin
        found = 1'b1;
        sel   = WID_W'(idx);
      end
    end
  end

  always_comb begin
    free_slot = '0;
    for (int k = NUM_WARPS - 1; k >= 0; k--)
      if (!occ[k]) free_slot = WID_W'(k);
  end

  assign launch_ready = ~&occ;
  assign launch_slot  = free_slot;
  assign launch_fire  = launch_valid & launch_ready;
  assign occupancy    = occ;
  assign issue_valid  = found;
  assign issue_warp   = sel;
  assign issue_pc     = pc[sel];
  assign issue_exit   = found & nxt_exit[sel];
  assign issue_load   = found & nxt_load[sel] & ~nxt_exit[sel];
  assign retire_valid = issue_exit;
  assign retire_slot  = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= '0;
      last <= WID_W'(NUM_WARPS - 1);
      for (int i = 0; i < NUM_WARPS; i++) begin
        pc[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      if (found) last <= sel;
      for (int i = 0; i < NUM_WARPS; i++) begin
        if (launch_fire && free_slot == WID_W'(i)) begin
          occ[i] <= 1'b1;
          pc[i]  <= launch_pc;
          cnt[i] <= '0;
        end else begin
          if (issue_exit && sel == WID_W'(i)) occ[i] <= 1'b0;
          if (found && sel == WID_W'(i)) pc[i] <= pc[i] + 1'b1;
          case ({inc_v[i], dec_v[i]})
            2'b10:   cnt[i] <= cnt[i] + 1'b1;
            2'b01:   cnt[i] <= cnt[i] - 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assert_issue_occupied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> occupancy[issue_warp]);

  assert_full_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_ready && !retire_valid) |=> $stable(occupancy));

  assert_launch_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready) |=> occupancy[$past(launch_slot)]);

  assert_retire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> !occupancy[$past(retire_slot)]);

  assert_exit_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_exit |-> cnt[issue_warp] == '0);

endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 24;
  localparam int PCW = 16;
  localparam int WW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch_valid = 1'b0, launch_ready;
  logic [PCW-1:0] launch_pc = '0, issue_pc;
  logic [WW-1:0] launch_slot, ret_warp = '0, issue_warp, retire_slot;
  logic [NW-1:0] occupancy, nxt_valid = '0, nxt_load = '0, nxt_dep = '0, nxt_exit = '0;
  logic ret_valid = 1'b0, issue_valid, issue_load, issue_exit, retire_valid;

  warp_issue_sched uut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_pc(launch_pc),
    .launch_ready(launch_ready), .launch_slot(launch_slot), .occupancy(occupancy),
    .nxt_valid(nxt_valid), .nxt_load(nxt_load), .nxt_dep(nxt_dep), .nxt_exit(nxt_exit),
    .ret_valid(ret_valid), .ret_warp(ret_warp), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .issue_pc(issue_pc), .issue_load(issue_load),
    .issue_exit(issue_exit), .retire_valid(retire_valid), .retire_slot(retire_slot));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit mocc [NW];
  int mpc [NW], mbase [NW], mcnt [NW];
  int mlast = NW - 1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // instruction class per warp: 0 plain, 1 load, 2 dependent, 3 exit
  function automatic int kind(int w);
    int rel;
    rel = (mpc[w] - mbase[w]) & 16'hffff;
    if (rel >= 10 + (w % 7)) return 3;
    case ((rel * 5 + w * 3) % 6)
      0, 3:    return 1;
      1, 4:    return 2;
      default: return 0;
    endcase
  endfunction

  task automatic cycle(bit lv, bit ven);
    int fr, sel, k, occv, rw;
    bit fnd, dec;
    bit el [NW];
    @(negedge clk);
    launch_valid = lv;
    launch_pc = PCW'($urandom);
    for (int w = 0; w < NW; w++) begin
      k = kind(w);
      nxt_valid[w] = ven && ($urandom % 4 != 0);
      nxt_load[w]  = (k == 1);
      nxt_dep[w]   = (k == 2);
      nxt_exit[w]  = (k == 3);
    end
    ret_valid = ($urandom % 3 != 0);
    rw = $urandom % NW;
    for (int j = 0; j < NW; j++)
      if (mcnt[(rw + j) % NW] > 0 && mcnt[rw] == 0) rw = (rw + j) % NW;
    ret_warp = WW'(rw);
    #1;
    fr = -1; occv = 0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (!mocc[w]) fr = w;
      if (mocc[w]) occv = occv | (1 << w);
    end
    for (int w = 0; w < NW; w++) begin
      k = kind(w);
      el[w] = mocc[w] && nxt_valid[w] && !((k == 2 || k == 3) && mcnt[w] > 0)
              && !(k == 1 && mcnt[w] >= 7);
    end
    fnd = 0; sel = 0;
    for (int j = 1; j <= NW; j++)
      if (!fnd && el[(mlast + j) % NW]) begin fnd = 1; sel = (mlast + j) % NW; end
    chk("R3 launch_ready", int'(launch_ready), int'(fr >= 0));
    if (fr >= 0) chk("R2 launch_slot", int'(launch_slot), fr);
    chk("R2 R3 R9 occupancy", int'(occupancy), occv);
    chk("R8 issue_valid", int'(issue_valid), int'(fnd));
    if (fnd) begin
      k = kind(sel);
      chk("R4 R5 R7 issue_warp", int'(issue_warp), sel);
      chk("R6 issue_pc", int'(issue_pc), mpc[sel] & 16'hffff);
      chk("R7 issue_load", int'(issue_load), int'(k == 1));
      chk("R9 retire_valid", int'(retire_valid), int'(k == 3));
      if (k == 3) chk("R9 retire_slot", int'(retire_slot), sel);
      chk("R10 issued warp occupied", int'(occupancy[issue_warp]), 1);
    end else chk("R9 retire idle", int'(retire_valid), 0);
    dec = ret_valid && mcnt[rw] > 0;
    if (fnd) begin
      k = kind(sel);
      mlast = sel;
      mpc[sel] = (mpc[sel] + 1) & 16'hffff;
      if (k == 3) mocc[sel] = 0;
      if (k == 1) mcnt[sel]++;
    end
    if (dec) mcnt[rw]--;
    if (lv && fr >= 0) begin
      mocc[fr] = 1; mpc[fr] = int'(launch_pc); mbase[fr] = int'(launch_pc); mcnt[fr] = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin mocc[w] = 0; mpc[w] = 0; mbase[w] = 0; mcnt[w] = 0; end
    nxt_valid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset launch_ready", int'(launch_ready), 1);
    chk("R1 reset occupancy", int'(occupancy), 0);
    chk("R1 reset issue_valid", int'(issue_valid), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 30; c++) cycle(1'b1, 1'b0);
    for (int c = 0; c < 3000; c++) cycle(($urandom % 3) == 0, (c % 50) < 40);
    for (int c = 0; c < 20; c++) cycle(1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule